// File: doc/BRIEF.md
# Virtual Address Segment Decoder

This block sorts a 32-bit virtual address into one of five fixed windows and checks that window against the current privilege level and an error-level override. The result takes one of three forms. For a window with a fixed mapping it gives the physical address, with read and write permission. For a window that needs paging it raises a request for the translation lookaside buffer. When the caller's privilege does not reach the window, it raises an address fault.

It sits in front of the translation buffer in a load/store or fetch path. The address, mode and error-level inputs are decoded by pure logic. The results can go straight to the outputs (`REG_OUT = 0`) or pass through one pipeline register (`REG_OUT = 1`, the default). With the register, the outputs clear while `rst_n` is low.

Top module: `vaddr_seg_decode`

## Requirements
- R1: Addresses with bit 31 clear (0x00000000 to 0x7FFFFFFF) raise `tlb_req` in every mode when `err_lvl` is 0.
- R2: Addresses with bit 31 clear are passed through unchanged as `pa`, with both permissions set, in every mode when `err_lvl` is 1.
- R3: Addresses 0x80000000 to 0x9FFFFFFF in kernel mode give `pa` = address minus 0x80000000, with both permissions set.
- R4: Addresses 0xA0000000 to 0xBFFFFFFF in kernel mode give `pa` = address minus 0xA0000000, with both permissions set.
- R5: Addresses 0xC0000000 to 0xDFFFFFFF raise `tlb_req` in kernel or supervisor mode and raise `addr_fault` in user mode.
- R6: Addresses 0xE0000000 to 0xFFFFFFFF raise `tlb_req` only in kernel mode. Any other mode raises `addr_fault`. For 0x80000000 to 0xBFFFFFFF, any mode other than kernel also raises `addr_fault`.
- R7: The mode encoding is 2'b00 kernel, 2'b01 supervisor, 2'b10 user. 2'b11 behaves exactly as user.
- R8: `tlb_req` and `addr_fault` are never high together. When either is high, `pa`, `perm_rd` and `perm_wr` are all 0.
- R9: With `REG_OUT = 1`, every output is 0 while `rst_n` is low. Results appear one clock after their inputs are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| va | input | 32 | Virtual address |
| priv_mode | input | 2 | 00 kernel, 01 supervisor, 10/11 user |
| err_lvl | input | 1 | Error-level override for the low window |
| pa | output | 32 | Physical address, 0 unless a fixed mapping applies |
| perm_rd | output | 1 | Read allowed |
| perm_wr | output | 1 | Write allowed |
| tlb_req | output | 1 | Address must be translated by the TLB |
| addr_fault | output | 1 | Privilege violation for this window |

## Verification
The only state is the output register. A fault in the decode shows at the ports on the very next clock: a request lands in the wrong window, a fault flag is missing, or an offset is not stripped. The risky cases sit at the window edges, so the bench drives the first and last address of every window. It does so in all four mode codes, with `err_lvl` both clear and set, and compares every output against an independent model one clock later.

// File: rtl/vaddr_seg_decode.sv
module vaddr_seg_decode #(
  parameter int  AW      = 32,
  parameter bit  REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] va,
  input  logic [1:0]    priv_mode,
  input  logic          err_lvl,
  output logic [AW-1:0] pa,
  output logic          perm_rd,
  output logic          perm_wr,
  output logic          tlb_req,
  output logic          addr_fault
);
  localparam int WIN = 3;
  localparam int OFS = AW - WIN;

  logic          is_kern, is_sup;
  logic [AW-1:0] pa_c;
  logic          rw_c, tlb_c, bad_c;

  assign is_kern = (priv_mode == 2'b00);
  assign is_sup  = (priv_mode == 2'b01);

  always_comb begin
    pa_c  = '0;
    rw_c  = 1'b0;
    tlb_c = 1'b0;
    bad_c = 1'b0;
    if (!va[AW-1]) begin
      if (err_lvl) begin
        pa_c = va;
        rw_c = 1'b1;
      end else begin
        tlb_c = 1'b1;
      end
    end else begin
      case (va[AW-2:OFS])
        2'b00, 2'b01: begin
          if (is_kern) begin
            pa_c = {{WIN{1'b0}}, va[OFS-1:0]};
            rw_c = 1'b1;
          end else begin
            bad_c = 1'b1;
          end
        end
        2'b10: begin
          tlb_c = is_kern | is_sup;
          bad_c = ~(is_kern | is_sup);
        end
        default: begin
          tlb_c = is_kern;
          bad_c = ~is_kern;
        end
      endcase
    end
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          pa         <= '0;
          perm_rd    <= 1'b0;
          perm_wr    <= 1'b0;
          tlb_req    <= 1'b0;
          addr_fault <= 1'b0;
        end else begin
          pa         <= pa_c;
          perm_rd    <= rw_c;
          perm_wr    <= rw_c;
          tlb_req    <= tlb_c;
          addr_fault <= bad_c;
        end
      end
    end else begin : g_comb
      assign pa         = pa_c;
      assign perm_rd    = rw_c;
      assign perm_wr    = rw_c;
      assign tlb_req    = tlb_c;
      assign addr_fault = bad_c;
    end
  endgenerate
endmodule

// File: rtl/vaddr_seg_decode_chk.sv
module vaddr_seg_decode_chk #(
  parameter int AW      = 32,
  parameter bit REG_OUT = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] va,
  input logic [1:0]    priv_mode,
  input logic          err_lvl,
  input logic [AW-1:0] pa,
  input logic          perm_rd,
  input logic          perm_wr,
  input logic          tlb_req,
  input logic          addr_fault
);
  logic [AW-1:0] va_d;
  logic [1:0]    mode_d;
  logic          erl_d, primed;

  generate
    if (REG_OUT) begin : g_dly
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          primed <= 1'b0;
          va_d   <= '0;
          mode_d <= 2'b00;
          erl_d  <= 1'b0;
        end else begin
          primed <= 1'b1;
          va_d   <= va;
          mode_d <= priv_mode;
          erl_d  <= err_lvl;
        end
      end
    end else begin : g_nodly
      assign primed = 1'b1;
      assign va_d   = va;
      assign mode_d = priv_mode;
      assign erl_d  = err_lvl;
    end
  endgenerate

  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(tlb_req && addr_fault));

  a_r8_pa_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (tlb_req || addr_fault) |-> (pa == '0 && !perm_rd && !perm_wr));

  a_r1_low_tlb: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !va_d[AW-1] && !erl_d) |-> tlb_req);

  a_r2_low_ident: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !va_d[AW-1] && erl_d) |-> (pa == va_d && perm_rd && perm_wr));

  a_r3_kseg_strip: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && va_d[AW-1:AW-2] == 2'b10 && mode_d == 2'b00)
      |-> (pa == {3'b000, va_d[AW-4:0]} && perm_rd));

  a_r7_user_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && va_d[AW-1] && mode_d[1]) |-> addr_fault);
endmodule

bind vaddr_seg_decode vaddr_seg_decode_chk #(.AW(AW), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/tb_vaddr_seg_decode.sv
module tb_vaddr_seg_decode;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] va;
  logic [1:0]  priv_mode;
  logic        err_lvl;
  logic [31:0] pa;
  logic        perm_rd, perm_wr, tlb_req, addr_fault;

  int applied = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vaddr_seg_decode dut (.*);

  localparam int NV = 12;
  localparam logic [31:0] ADDRS [NV] = '{
    32'h0000_0000, 32'h1234_5678, 32'h7FFF_FFFF, 32'h8000_0000,
    32'h8ABC_DEF0, 32'h9FFF_FFFF, 32'hA000_0000, 32'hBFFF_FFFF,
    32'hC000_0000, 32'hDFFF_FFFF, 32'hE000_0000, 32'hFFFF_FFFF };

  function automatic string req_of(input logic [31:0] a, input logic [1:0] m, input logic e);
    if (!a[31])                 return e ? "R2" : "R1";
    if (m == 2'b11)             return "R7";
    if (a[31:29] == 3'b100)     return (m == 2'b00) ? "R3" : "R6";
    if (a[31:29] == 3'b101)     return (m == 2'b00) ? "R4" : "R6";
    if (a[31:29] == 3'b110)     return "R5";
    return "R6";
  endfunction

  task automatic model(input logic [31:0] a, input logic [1:0] m, input logic e,
                       output logic [35:0] x);
    logic k, s;
    k = (m == 2'b00);
    s = (m == 2'b01);
    x = '0;
    if (a < 32'h8000_0000) begin
      if (e) x = {a, 4'b1100}; else x[1] = 1'b1;
    end else if (a < 32'hA000_0000) begin
      if (k) x = {a - 32'h8000_0000, 4'b1100}; else x[0] = 1'b1;
    end else if (a < 32'hC000_0000) begin
      if (k) x = {a - 32'hA000_0000, 4'b1100}; else x[0] = 1'b1;
    end else if (a < 32'hE000_0000) begin
      if (k || s) x[1] = 1'b1; else x[0] = 1'b1;
    end else begin
      if (k) x[1] = 1'b1; else x[0] = 1'b1;
    end
  endtask

  task automatic check(input string r, input logic [35:0] exp);
    logic [35:0] act;
    act = {pa, perm_rd, perm_wr, tlb_req, addr_fault};
    applied++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s va=%h mode=%b erl=%b actual=%h expected=%h",
               r, va, priv_mode, err_lvl, act, exp);
    end
  endtask

  initial begin
    #20000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end

  initial begin
    logic [35:0] exp;
    rst_n = 1'b0; va = 32'hFFFF_FFFF; priv_mode = 2'b10; err_lvl = 1'b0;
    repeat (3) @(negedge clk);
    check("R9", 36'h0);
    rst_n = 1'b1;
    for (int e = 0; e < 2; e++) begin
      for (int m = 0; m < 4; m++) begin
        for (int i = 0; i < NV; i++) begin
          va = ADDRS[i]; priv_mode = 2'(m); err_lvl = 1'(e);
          @(negedge clk);
          model(va, priv_mode, err_lvl, exp);
          check(req_of(va, priv_mode, err_lvl), exp);
        end
      end
    end
    // R9: output holds last sampled result until the next edge, one clock of latency
    va = 32'h9000_0000; priv_mode = 2'b00; err_lvl = 1'b0;
    @(negedge clk);
    va = 32'hE000_0000; priv_mode = 2'b01;
    #1;
    check("R9", {32'h1000_0000, 4'b1100});
    @(negedge clk);
    check("R9", 36'h1);
    // R8: fault then kernel high window, pa must return to zero with tlb_req
    va = 32'hFFFF_FFF0; priv_mode = 2'b00;
    @(negedge clk);
    check("R8", 36'h2);
    // R9: reset clears a live result
    va = 32'hBFFF_FFFF;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9", 36'h0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule